// File: doc/BRIEF.md
# Aligned Linear-Burst DMA Address Sequencer

This block produces the address-phase sequence for a bus-master DMA engine. A start pulse loads a double-word start address, a transfer count, a direction, two burst permissions (one for reads, one for writes) and a 3-bit burst-length code. The block then presents one transfer at a time on its address outputs. Each transfer completes on a cycle where `ready` is sampled high, and the address then moves up one double word.

When linear bursting is allowed, the block first issues strobed single accesses until the running address lands on a burst-length boundary. It then switches to linear bursts in the same tenure. The first transfer of a burst carries the address strobe and raises `burstLast` to announce the burst. Later transfers in the burst have no strobe. `burstLast` drops on the transfer that closes the burst or uses up the count. When the count runs out, the block reports completion with a one-cycle `done` pulse.

Top module: `dma_burst_seq`

## Requirements
- R1: After reset, `busy`, `addrStrobe`, `burstLast`, `done` and `codeErr` are 0, and `byteEn` is 4'b0000.
- R2: The burst-length code selects the burst length: 3'b001 gives 4 double words (busAddr[1:0] vary), 3'b010 gives 8 (busAddr[2:0] vary) and 3'b100 gives 16 (busAddr[3:0] vary). Code 3'b000 turns linear bursting off.
- R3: Any other code value turns linear bursting off and sets `codeErr` from the cycle after the start until the next start.
- R4: Linear bursting is used only if `rdBurstEn` is set for a read (`isWrite`=0) or `wrBurstEn` is set for a write (`isWrite`=1). Otherwise every transfer is a strobed single with `burstLast`=0.
- R5: While the running address is not on a burst boundary, each transfer is a single access with `addrStrobe`=1 and `burstLast`=0.
- R6: When the running address reaches a boundary, a linear burst starts without `busy` dropping. Its first transfer has `addrStrobe`=1 and, unless it is also the final transfer, `burstLast`=1.
- R7: Within a linear burst, `addrStrobe` is 1 only on the first transfer. `burstLast` is 0 only on the transfer whose address is the last one of the burst.
- R8: If the count runs out inside a burst, the final transfer has `burstLast`=0 and no further transfer is presented.
- R9: A transfer completes only when `ready` is high. The address then increments by one double word. While `ready` is low, the address and control outputs hold.
- R10: A start with a count of 0 presents no transfer and gives a `done` pulse.
- R11: `byteEn` is 4'b1111 (active high, all lanes) while a transfer is presented, and 4'b0000 otherwise.
- R12: `done` is high for exactly one cycle after the final transfer completes. In that cycle `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted when not busy |
| isWrite | input | 1 | Direction of the tenure: 1 for write |
| startAddr | input | 30 | Start double-word address (byte address bits 31:2) |
| xferCount | input | 8 | Number of double-word transfers |
| rdBurstEn | input | 1 | Allow linear bursts for reads |
| wrBurstEn | input | 1 | Allow linear bursts for writes |
| burstCode | input | 3 | Burst-length code |
| ready | input | 1 | Current transfer completes on this cycle |
| busAddr | output | 30 | Current double-word address |
| byteEn | output | 4 | Byte lane enables, active high |
| addrStrobe | output | 1 | Address strobe for the current transfer |
| burstLast | output | 1 | High while more burst transfers follow |
| busy | output | 1 | Tenure in progress |
| done | output | 1 | One-cycle completion pulse |
| codeErr | output | 1 | Illegal burst code loaded at the last start |

## Verification
The bench starts an unaligned tenure and checks the change from strobed singles to a linear burst at the boundary. A design that bursts too early would drop the strobe on an unaligned address. A design that never switches would strobe every transfer. Counts that end inside a burst check that `burstLast` falls on the final transfer, where a design that tracks only the boundary would leave it high. Wait states check that the address holds, since a design that ignores `ready` would skip addresses. Illegal codes, a burst permission that does not match the direction, and a zero count check that bursting stays off and that `done` still pulses.

// File: rtl/dma_burst_pkg.sv
package dma_burst_pkg;
  localparam int OFF_W = 4;

  typedef struct packed {
    logic load;
    logic advance;
  } seqStrobe_t;

  typedef struct packed {
    logic linEn;
    logic aligned;
    logic lastInBurst;
    logic lastCount;
    logic cntZero;
  } dpStatus_t;

  function automatic logic codeLegal(input logic [2:0] code);
    return (code == 3'b000) || (code == 3'b001) || (code == 3'b010) || (code == 3'b100);
  endfunction

  function automatic logic [OFF_W-1:0] codeMask(input logic [2:0] code);
    case (code)
      3'b001:  return 4'b0011;
      3'b010:  return 4'b0111;
      3'b100:  return 4'b1111;
      default: return 4'b0000;
    endcase
  endfunction
endpackage

// File: rtl/dma_burst_dp.sv
module dma_burst_dp
  import dma_burst_pkg::*;
#(
  parameter int ADDR_W = 30,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [CNT_W-1:0]  xferCount,
  input  logic              isWrite,
  input  logic              rdBurstEn,
  input  logic              wrBurstEn,
  input  logic [2:0]        burstCode,
  output logic [ADDR_W-1:0] curAddr,
  output dpStatus_t         stat,
  output logic              codeErr
);
  logic [CNT_W-1:0] remain;
  logic [OFF_W-1:0] offMask;
  logic             linEnR;
  logic [OFF_W-1:0] offBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr <= '0;
      remain  <= '0;
      offMask <= '0;
      linEnR  <= 1'b0;
      codeErr <= 1'b0;
    end else if (strb.load) begin
      curAddr <= startAddr;
      remain  <= xferCount;
      offMask <= codeMask(burstCode);
      linEnR  <= codeLegal(burstCode) && (burstCode != 3'b000) &&
                 (isWrite ? wrBurstEn : rdBurstEn);
      codeErr <= !codeLegal(burstCode);
    end else if (strb.advance) begin
      curAddr <= curAddr + 1'b1;
      remain  <= remain - 1'b1;
    end
  end

  assign offBits          = curAddr[OFF_W-1:0] & offMask;
  assign stat.linEn       = linEnR;
  assign stat.aligned     = (offBits == '0);
  assign stat.lastInBurst = (offBits == offMask);
  assign stat.lastCount   = (remain == CNT_W'(1));
  assign stat.cntZero     = (remain == '0);
endmodule

// File: rtl/dma_burst_ctrl.sv
module dma_burst_ctrl
  import dma_burst_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       ready,
  input  dpStatus_t  stat,
  output seqStrobe_t strb,
  output logic       active,
  output logic       addrStrobe,
  output logic       burstLast,
  output logic       busy,
  output logic       done
);
  logic inBurst;
  logic curBurst;
  logic endNow;

  assign active     = busy && !stat.cntZero;
  assign curBurst   = active && stat.linEn && (inBurst || stat.aligned);
  assign addrStrobe = active && !(curBurst && inBurst);
  assign burstLast  = curBurst && !(stat.lastInBurst || stat.lastCount);
  assign strb.load    = start && !busy;
  assign strb.advance = active && ready;
  assign endNow     = (busy && stat.cntZero) || (strb.advance && stat.lastCount);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      inBurst <= 1'b0;
    end else begin
      done <= endNow;
      if (strb.load) begin
        busy    <= 1'b1;
        inBurst <= 1'b0;
      end else if (endNow) begin
        busy    <= 1'b0;
        inBurst <= 1'b0;
      end else if (strb.advance) begin
        inBurst <= curBurst && !stat.lastInBurst;
      end
    end
  end
endmodule

// File: rtl/dma_burst_seq.sv
module dma_burst_seq
  import dma_burst_pkg::*;
#(
  parameter int ADDR_W = 30,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              isWrite,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [CNT_W-1:0]  xferCount,
  input  logic              rdBurstEn,
  input  logic              wrBurstEn,
  input  logic [2:0]        burstCode,
  input  logic              ready,
  output logic [ADDR_W-1:0] busAddr,
  output logic [3:0]        byteEn,
  output logic              addrStrobe,
  output logic              burstLast,
  output logic              busy,
  output logic              done,
  output logic              codeErr
);
  seqStrobe_t strb;
  dpStatus_t  stat;
  logic       active;

  dma_burst_dp #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .startAddr(startAddr),
    .xferCount(xferCount), .isWrite(isWrite), .rdBurstEn(rdBurstEn),
    .wrBurstEn(wrBurstEn), .burstCode(burstCode), .curAddr(busAddr),
    .stat(stat), .codeErr(codeErr)
  );

  dma_burst_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .ready(ready), .stat(stat),
    .strb(strb), .active(active), .addrStrobe(addrStrobe),
    .burstLast(burstLast), .busy(busy), .done(done)
  );

  assign byteEn = active ? 4'b1111 : 4'b0000;
endmodule

// File: rtl/dma_burst_seq_chk.sv
module dma_burst_seq_chk #(
  parameter int ADDR_W = 30
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [2:0]        burstCode,
  input logic              ready,
  input logic [ADDR_W-1:0] busAddr,
  input logic [3:0]        byteEn,
  input logic              addrStrobe,
  input logic              burstLast,
  input logic              busy,
  input logic              done,
  input logic              codeErr
);
  logic xfer;
  logic badCode;
  assign xfer    = (byteEn == 4'b1111);
  assign badCode = !((burstCode == 3'b000) || (burstCode == 3'b001) ||
                     (burstCode == 3'b010) || (burstCode == 3'b100));

  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (xfer && !ready) |=> ($stable(busAddr) && $stable(addrStrobe) && $stable(burstLast)));

  assert_addr_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    (xfer && ready) |=> (!xfer || busAddr == $past(busAddr) + 1'b1));

  assert_strobe_gated_R11: assert property (@(posedge clk) disable iff (!rstN)
    (addrStrobe || burstLast) |-> xfer);

  assert_burst_cont_R7: assert property (@(posedge clk) disable iff (!rstN)
    (xfer && ready && burstLast) |=> (xfer && !addrStrobe));

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && !xfer) ##1 !done);

  assert_code_err_R3: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && badCode) |=> codeErr);
endmodule

bind dma_burst_seq dma_burst_seq_chk #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .start(start), .burstCode(burstCode), .ready(ready),
  .busAddr(busAddr), .byteEn(byteEn), .addrStrobe(addrStrobe),
  .burstLast(burstLast), .busy(busy), .done(done), .codeErr(codeErr)
);

// File: tb/dma_burst_seq_test.sv
module dma_burst_seq_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        isWrite = 1'b0;
  logic [29:0] startAddr = '0;
  logic [7:0]  xferCount = '0;
  logic        rdBurstEn = 1'b0;
  logic        wrBurstEn = 1'b0;
  logic [2:0]  burstCode = 3'b000;
  logic        ready = 1'b0;
  logic [29:0] busAddr;
  logic [3:0]  byteEn;
  logic        addrStrobe, burstLast, busy, done, codeErr;

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  dma_burst_seq uut (
    .clk(clk), .rstN(rstN), .start(start), .isWrite(isWrite),
    .startAddr(startAddr), .xferCount(xferCount), .rdBurstEn(rdBurstEn),
    .wrBurstEn(wrBurstEn), .burstCode(burstCode), .ready(ready),
    .busAddr(busAddr), .byteEn(byteEn), .addrStrobe(addrStrobe),
    .burstLast(burstLast), .busy(busy), .done(done), .codeErr(codeErr)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      testsFailed++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  // Runs one tenure; expected strobe and burst-last are derived from the
  // burst length (1 << lenBits double words, 0 = no bursting) and the count.
  task automatic runTenure(input string req, input logic [29:0] a0, input int cnt,
                           input logic wr, input logic rdE, input logic wrE,
                           input logic [2:0] code, input int lenBits,
                           input logic expErr, input int waitMode);
    int burstLen = (lenBits == 0) ? 0 : (1 << lenBits);
    int idx = 0;
    int posInBurst = -1;   // -1: not inside a burst
    int burstLeft = 0;
    logic [29:0] expA = a0;
    logic sawDone = 1'b0;
    int guard = 0;
    @(negedge clk);
    isWrite = wr; startAddr = a0; xferCount = 8'(cnt);
    rdBurstEn = rdE; wrBurstEn = wrE; burstCode = code; start = 1'b1;
    while (!sawDone && guard < 400) begin
      logic rdy;
      logic expStb, expLast;
      @(negedge clk);
      start = 1'b0;
      guard++;
      rdy = (waitMode == 0) ? 1'b1 : ((guard % 3) != 0);
      ready = rdy;
      if (done) begin
        sawDone = 1'b1;
        check({req, " R12 busy low at done"}, busy, 1'b0);
        check({req, " R11 lanes idle at done"}, byteEn, 4'b0000);
      end else if (byteEn == 4'b1111) begin
        if (posInBurst < 0 && burstLen != 0 && (expA % burstLen) == 0) begin
          posInBurst = 0;
          burstLeft = burstLen;
        end
        expStb = (posInBurst <= 0);
        expLast = (posInBurst >= 0) && (posInBurst != burstLen - 1) && (idx != cnt - 1);
        check({req, " R9 address"}, busAddr, expA);
        check({req, " R5/R6/R7 strobe"}, addrStrobe, expStb);
        check({req, " R7/R8 burstLast"}, burstLast, expLast);
        check({req, " R6 busy held"}, busy, 1'b1);
        if (rdy) begin
          idx++;
          expA++;
          if (posInBurst >= 0) begin
            posInBurst++;
            if (posInBurst == burstLen) posInBurst = -1;
          end
        end
      end
    end
    ready = 1'b0;
    check({req, " R12 done seen"}, sawDone, 1'b1);
    check({req, " R8 transfer count"}, idx, cnt);
    check({req, " R3 codeErr"}, codeErr, expErr);
  endtask

  task automatic testReset();
    check("R1 busy", busy, 1'b0);
    check("R1 strobe", addrStrobe, 1'b0);
    check("R1 burstLast", burstLast, 1'b0);
    check("R1 done", done, 1'b0);
    check("R1 codeErr", codeErr, 1'b0);
    check("R1 R11 byteEn", byteEn, 4'b0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    // R2 R5 R6 R8: unaligned read, 4-word bursts, count ends mid burst
    runTenure("r2_len4", 30'h0000_0101, 10, 1'b0, 1'b1, 1'b0, 3'b001, 2, 1'b0, 0);
    // R2: 8-word bursts on a write
    runTenure("r2_len8", 30'h0000_0203, 14, 1'b1, 1'b0, 1'b1, 3'b010, 3, 1'b0, 0);
    // R2 R7: aligned 16-word burst, exact length
    runTenure("r2_len16", 30'h0000_0310, 16, 1'b0, 1'b1, 1'b0, 3'b100, 4, 1'b0, 0);
    // R4: write with only read bursting allowed
    runTenure("r4_dir", 30'h0000_0400, 6, 1'b1, 1'b1, 1'b0, 3'b001, 0, 1'b0, 0);
    // R2: code 000 disables
    runTenure("r2_off", 30'h0000_0500, 5, 1'b0, 1'b1, 1'b1, 3'b000, 0, 1'b0, 0);
    // R3: illegal code, then legal code clears flag
    runTenure("r3_bad", 30'h0000_0600, 5, 1'b0, 1'b1, 1'b1, 3'b011, 0, 1'b1, 0);
    runTenure("r3_clear", 30'h0000_0606, 4, 1'b0, 1'b1, 1'b1, 3'b001, 2, 1'b0, 0);
    // R9: wait states across single and burst transfers
    runTenure("r9_wait", 30'h0000_0702, 9, 1'b0, 1'b1, 1'b0, 3'b001, 2, 1'b0, 1);
    // R8: count ends before reaching the boundary
    runTenure("r8_short", 30'h0000_0801, 2, 1'b0, 1'b1, 1'b0, 3'b100, 4, 1'b0, 0);
    // R8: single transfer on an aligned address
    runTenure("r8_one", 30'h0000_0900, 1, 1'b0, 1'b1, 1'b0, 3'b001, 2, 1'b0, 0);
    // R10: zero count
    runTenure("r10_zero", 30'h0000_0A00, 0, 1'b0, 1'b1, 1'b0, 3'b001, 2, 1'b0, 0);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule